// File: doc/BRIEF.md
# I2C Master Address Phase Controller

This block runs the opening of an I2C master transaction. When idle it accepts a one-cycle start request. On that request it captures an 8-bit target byte, which holds a 7-bit target address and a direction bit. It then creates a START condition and clocks the byte out most significant bit first. On the ninth clock it reads back the target's acknowledge. The outcome picks one of three results. The block enters master-transmit mode, enters master-receive mode, or abandons the transfer. When it abandons the transfer it issues STOP and records a bus error without software help.

Both bus lines are open-drain. The block asserts a pull-low enable for each line and reads the resolved SDA level back. The SCL half-period is a number of system clocks. This number is captured from a programmable divider input when the request is accepted. After a successful address phase the block keeps SCL low, which holds the bus for the data-phase logic. Its mode output then tells that logic which direction to use. The block stays in this handoff state until reset.

Top module: `i2c_addr_phase`

## Requirements
- R1: After reset both pull-low outputs are 0, mode is 0 (idle), busy is 0, bus_err is 0, and done and abort are 0.
- R2: A start request while idle opens the transfer. In the following cycle busy is 1, SDA is pulled low and SCL is released, which forms a START. SCL is pulled low one half-period later.
- R3: Nine SCL pulses follow START. The first eight carry the captured byte most significant bit first, so bits 7..1 are the address and bit 0 is the direction. SDA never changes while SCL is released, except at START and STOP.
- R4: Each SCL low and high phase lasts exactly `half_div` clock cycles, using the value captured at the start request. A captured value of 0 selects the default `DEF_HALF` (4).
- R5: During the ninth pulse the block releases SDA. It takes the acknowledge from the SDA level at the end of the SCL high phase, where 0 means acknowledge.
- R6: On acknowledge with direction bit 0, mode becomes 1 (master-transmit), done pulses high for one cycle and busy falls. SCL stays pulled low from then on.
- R7: On acknowledge with direction bit 1, mode becomes 2 (master-receive) right after the ninth pulse, with the same done pulse and busy behaviour as R6.
- R8: On not-acknowledge, the block pulls SCL and SDA low and then releases SCL. After one half-period it releases SDA, which forms a STOP. Abort pulses for one cycle as SDA is released, and busy falls. Mode stays 0.
- R9: bus_err is set when the not-acknowledge is seen and stays set through later transfers until err_clr is 1 for a cycle. If a set and a clear arrive in the same cycle, the set wins.
- R10: A start request is ignored while busy is 1 and after a handoff. It causes no second START and does not change the byte or the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request to open a transfer |
| tgt_byte | input | 8 | Address in bits 7..1, direction in bit 0 (1 = read) |
| half_div | input | DIV_W | SCL half-period in clock cycles, 0 selects DEF_HALF |
| err_clr | input | 1 | Write-one-to-clear strobe for bus_err |
| sda_in | input | 1 | Resolved SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| mode | output | 2 | 0 idle, 1 master-transmit, 2 master-receive |
| busy | output | 1 | High from START until STOP or handoff |
| done | output | 1 | One-cycle strobe on acknowledged address |
| abort | output | 1 | One-cycle strobe when the abort STOP completes |
| bus_err | output | 1 | Sticky not-acknowledge error flag |

## Verification
The bench models an open-drain target that decodes START, STOP and every bit from the resolved lines. It can acknowledge or stay silent. An off-by-one bit counter would send a byte that is shifted or one bit short. Sampling the ninth bit at the wrong moment would turn a silent target into an acknowledge. The bench measures the SCL high width against the programmed divider and against the zero-means-default case, which catches a divider that counts one too many or too few. It checks that a failed transfer leaves a real STOP on the wire, and that a later successful transfer does not clear the error flag. It also sends a second start request mid-byte and after handoff, which exposes a controller that restarts instead of ignoring it.

// File: rtl/i2c_ap_pkg.sv
package i2c_ap_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_SCLDN,
        ST_BLO,
        ST_BHI,
        ST_ALO,
        ST_AHI,
        ST_PLO,
        ST_PHI,
        ST_HAND
    } ap_state_t;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_MTX  = 2'd1,
        MODE_MRX  = 2'd2
    } ap_mode_t;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } line_drive_t;

    function automatic line_drive_t drive_for(ap_state_t st, logic cur_bit);
        line_drive_t d;
        d.scl_low = 1'b0;
        d.sda_low = 1'b0;
        case (st)
            ST_START: d.sda_low = 1'b1;
            ST_SCLDN: begin d.scl_low = 1'b1; d.sda_low = 1'b1; end
            ST_BLO:   begin d.scl_low = 1'b1; d.sda_low = ~cur_bit; end
            ST_BHI:   d.sda_low = ~cur_bit;
            ST_ALO:   d.scl_low = 1'b1;
            ST_PLO:   begin d.scl_low = 1'b1; d.sda_low = 1'b1; end
            ST_PHI:   d.sda_low = 1'b1;
            ST_HAND:  d.scl_low = 1'b1;
            default:  ;
        endcase
        return d;
    endfunction

    function automatic logic is_active(ap_state_t st);
        return (st != ST_IDLE) && (st != ST_HAND);
    endfunction

endpackage

// File: rtl/i2c_ap_tick.sv
module i2c_ap_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] period,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = (cnt_q == period - DIV_W'(1));
    assign tick   = run && at_end;

    always_ff @(posedge clk) begin
        if (rst || !run || at_end)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/i2c_ap_shift.sv
module i2c_ap_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              shift,
    output logic              msb
);
    logic [BYTE_W-1:0] sr_q;

    assign msb = sr_q[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst)
            sr_q <= '1;
        else if (load)
            sr_q <= load_val;
        else if (shift)
            sr_q <= {sr_q[BYTE_W-2:0], 1'b1};
    end
endmodule

// File: rtl/i2c_ap_errflag.sv
module i2c_ap_errflag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/i2c_addr_phase.sv
module i2c_addr_phase
    import i2c_ap_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int DEF_HALF = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic [7:0]       tgt_byte,
    input  logic [DIV_W-1:0] half_div,
    input  logic             err_clr,
    input  logic             sda_in,
    output logic             scl_pull,
    output logic             sda_pull,
    output logic [1:0]       mode,
    output logic             busy,
    output logic             done,
    output logic             abort,
    output logic             bus_err
);
    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
    localparam logic [DIV_W-1:0] DEF_DIV  = DIV_W'(DEF_HALF);

    ap_state_t        st_q, st_d;
    ap_mode_t         mode_q;
    logic [BIT_W-1:0] bidx_q;
    logic [DIV_W-1:0] half_q;
    logic             dir_q;
    logic             tick, cur_bit, accept, nack_set;
    logic             done_q, abort_q;
    line_drive_t      drv;

    assign accept   = (st_q == ST_IDLE) && start_req;
    assign nack_set = (st_q == ST_AHI) && tick && sda_in;

    i2c_ap_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .run    (is_active(st_q)),
        .period (half_q),
        .tick   (tick)
    );

    i2c_ap_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (tgt_byte),
        .shift    ((st_q == ST_BHI) && tick),
        .msb      (cur_bit)
    );

    i2c_ap_errflag u_err (
        .clk  (clk),
        .rst  (rst),
        .set  (nack_set),
        .clr  (err_clr),
        .flag (bus_err)
    );

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:  if (start_req) st_d = ST_START;
            ST_START: if (tick) st_d = ST_SCLDN;
            ST_SCLDN: if (tick) st_d = ST_BLO;
            ST_BLO:   if (tick) st_d = ST_BHI;
            ST_BHI:   if (tick) st_d = (bidx_q == LAST_BIT) ? ST_ALO : ST_BLO;
            ST_ALO:   if (tick) st_d = ST_AHI;
            ST_AHI:   if (tick) st_d = sda_in ? ST_PLO : ST_HAND;
            ST_PLO:   if (tick) st_d = ST_PHI;
            ST_PHI:   if (tick) st_d = ST_IDLE;
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            mode_q  <= MODE_IDLE;
            bidx_q  <= '0;
            half_q  <= DEF_DIV;
            dir_q   <= 1'b0;
            done_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            done_q  <= (st_q == ST_AHI) && tick && !sda_in;
            abort_q <= (st_q == ST_PHI) && tick;
            if (accept) begin
                half_q <= (half_div == '0) ? DEF_DIV : half_div;
                dir_q  <= tgt_byte[0];
                bidx_q <= '0;
            end
            if ((st_q == ST_BHI) && tick)
                bidx_q <= bidx_q + BIT_W'(1);
            if ((st_q == ST_AHI) && tick && !sda_in)
                mode_q <= dir_q ? MODE_MRX : MODE_MTX;
        end
    end

    assign drv      = drive_for(st_q, cur_bit);
    assign scl_pull = drv.scl_low;
    assign sda_pull = drv.sda_low;
    assign mode     = mode_q;
    assign busy     = is_active(st_q);
    assign done     = done_q;
    assign abort    = abort_q;
endmodule

// File: rtl/i2c_addr_phase_chk.sv
module i2c_addr_phase_chk (
    input logic       clk,
    input logic       rst,
    input logic       err_clr,
    input logic       scl_pull,
    input logic       sda_pull,
    input logic [1:0] mode,
    input logic       busy,
    input logic       done,
    input logic       abort,
    input logic       bus_err
);
    a_r2_start_shape: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (sda_pull && !scl_pull));

    a_r3_sda_steady_high_scl: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !scl_pull && $past(!scl_pull)) |-> $stable(sda_pull));

    a_r6_done_handoff: assert property (@(posedge clk) disable iff (rst)
        done |-> (mode != 2'd0 && !busy && scl_pull));

    a_r8_abort_clean: assert property (@(posedge clk) disable iff (rst)
        abort |-> (mode == 2'd0 && !busy && bus_err && !sda_pull && !scl_pull));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (bus_err && !err_clr) |=> bus_err);

    a_r9_err_set_in_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_err) |-> (busy && scl_pull && sda_pull));

    a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(mode) == 2'd0);

    a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && abort));
endmodule

bind i2c_addr_phase i2c_addr_phase_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .err_clr  (err_clr),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .mode     (mode),
    .busy     (busy),
    .done     (done),
    .abort    (abort),
    .bus_err  (bus_err)
);

// File: tb/i2c_addr_phase_test.sv
module i2c_addr_phase_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_req = 1'b0;
    logic [7:0] tgt_byte = 8'h00;
    logic [7:0] half_div = 8'd0;
    logic       err_clr = 1'b0;
    logic       scl_pull, sda_pull, busy, done, abort, bus_err;
    logic [1:0] mode;

    logic slv_pull = 1'b0;
    logic ack_en = 1'b0;
    logic scl_line, sda_line;
    assign scl_line = !scl_pull;
    assign sda_line = !(sda_pull || slv_pull);

    int checks = 0;
    int errors = 0;

    logic       prev_scl = 1'b1, prev_sda = 1'b1;
    int         start_cnt = 0, stop_cnt = 0, done_cnt = 0, abort_cnt = 0;
    int         bitcnt = 0, hi_run = 0, hi_len = 0;
    logic [7:0] rx = 8'h00;
    logic       ninth = 1'b0;

    always #2 clk = ~clk;

    i2c_addr_phase uut (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .tgt_byte  (tgt_byte),
        .half_div  (half_div),
        .err_clr   (err_clr),
        .sda_in    (sda_line),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull),
        .mode      (mode),
        .busy      (busy),
        .done      (done),
        .abort     (abort),
        .bus_err   (bus_err)
    );

    // open-drain target model and bus monitor
    always @(posedge clk) begin
        if (done) done_cnt <= done_cnt + 1;
        if (abort) abort_cnt <= abort_cnt + 1;
        if (prev_scl && scl_line && prev_sda && !sda_line) begin
            start_cnt <= start_cnt + 1;
            bitcnt <= 0;
        end
        if (prev_scl && scl_line && !prev_sda && sda_line)
            stop_cnt <= stop_cnt + 1;
        if (!prev_scl && scl_line) begin
            if (bitcnt < 8) rx <= {rx[6:0], sda_line};
            if (bitcnt == 8) ninth <= sda_line;
            bitcnt <= bitcnt + 1;
            hi_run <= 1;
        end else if (scl_line) begin
            hi_run <= hi_run + 1;
        end
        if (prev_scl && !scl_line) begin
            hi_len <= hi_run;
            if (bitcnt == 8 && ack_en) slv_pull <= 1'b1;
            if (bitcnt == 9) slv_pull <= 1'b0;
        end
        prev_scl <= scl_line;
        prev_sda <= sda_line;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        slv_pull = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_mon();
        start_cnt = 0; stop_cnt = 0; done_cnt = 0; abort_cnt = 0;
        rx = 8'h00; ninth = 1'b0;
    endtask

    // launch a transfer; optionally fire a second request mid-byte
    task automatic launch(input logic [7:0] b, input logic [7:0] dv,
                          input logic ack, input logic poke);
        clear_mon();
        ack_en = ack;
        tgt_byte = b;
        half_div = dv;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        check("R2 busy after request", busy, 1);
        check("R2 SDA pulled at START", sda_pull, 1);
        check("R2 SCL released at START", scl_pull, 0);
        if (poke) begin
            repeat (20) @(negedge clk);
            tgt_byte = ~b;
            start_req = 1'b1;
            @(negedge clk);
            start_req = 1'b0;
        end
        for (int i = 0; i < 3000; i++) begin
            if (done_cnt + abort_cnt > 0) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 scl_pull", scl_pull, 0);
        check("R1 sda_pull", sda_pull, 0);
        check("R1 mode", mode, 0);
        check("R1 busy", busy, 0);
        check("R1 bus_err", bus_err, 0);
        check("R1 done/abort", done | abort, 0);
    endtask

    task automatic t_write_ack();
        do_reset();
        launch(8'h5A, 8'd3, 1'b1, 1'b1);
        check("R2 one START", start_cnt, 1);
        check("R3 byte on wire", rx, 8'h5A);
        check("R4 SCL high width", hi_len, 3);
        check("R5 ack seen on ninth", ninth, 0);
        check("R6 mode transmit", mode, 1);
        check("R6 done count", done_cnt, 1);
        check("R6 busy low", busy, 0);
        check("R6 SCL held", scl_pull, 1);
        check("R6 no STOP", stop_cnt, 0);
        check("R10 restart ignored mid-byte", rx, 8'h5A);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        repeat (10) @(negedge clk);
        check("R10 no START after handoff", start_cnt, 1);
        check("R10 busy stays low", busy, 0);
        check("R10 mode kept", mode, 1);
    endtask

    task automatic t_read_ack_default();
        do_reset();
        launch(8'h67, 8'd0, 1'b1, 1'b0);
        check("R3 read byte", rx, 8'h67);
        check("R4 default half-period", hi_len, 4);
        check("R7 mode receive", mode, 2);
        check("R7 done count", done_cnt, 1);
        check("R7 busy low", busy, 0);
    endtask

    task automatic t_nack_and_sticky();
        do_reset();
        launch(8'h22, 8'd2, 1'b0, 1'b0);
        check("R3 nack byte", rx, 8'h22);
        check("R4 SCL high width", hi_len, 2);
        check("R5 released SDA on ninth", ninth, 1);
        check("R8 STOP issued", stop_cnt, 1);
        check("R8 abort count", abort_cnt, 1);
        check("R8 mode idle", mode, 0);
        check("R8 busy low", busy, 0);
        check("R8 lines released", scl_pull | sda_pull, 0);
        check("R9 bus_err set", bus_err, 1);
        repeat (20) @(negedge clk);
        check("R9 bus_err held", bus_err, 1);
        launch(8'hA4, 8'd2, 1'b1, 1'b0);
        check("R9 survives good transfer", bus_err, 1);
        check("R9 later transfer mode", mode, 1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check("R9 cleared by strobe", bus_err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_write_ack();
        t_read_ack_default();
        t_nack_and_sticky();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule